// File: doc/BRIEF.md
# Dual-Port Frame Buffer with Row-Transfer Serial Port

This block is a word-addressable storage array with two independent ways in. A random-access port reads and writes single words, addressed by row and column. A second, output-only serial port streams words to a display refresh path. On request, the serial port takes a copy of an entire array row in one operation. The row is opened into a row-wide latch, and the latch is copied whole into a serial register that sits next to it.

Once the copy is in place, a serial-enable strobe steps through the register one word at a time. Stepping starts at a column offset chosen with the request and wraps back to column zero. While the serial register is being stepped, the random port keeps full use of the array. Random traffic and serial traffic therefore meet only during the short stall that each row copy costs.

Sizes are parameters: the row count, the row width in bits and the word width. The row width must be a whole multiple of the word width.

Top module: `vfb_top`

## Requirements
- R1: While reset is held and just after it is released, `rp_busy` is 0, `rp_rvalid` is 0 and `ser_data` is 0.
- R2: When `rp_req=1`, `rp_we=1` and the block is not busy, `rp_wdata` is stored into word `rp_col` of row `rp_row`. Word c occupies bits c*WORD_BITS upward within its row. When `rp_req=1`, `rp_we=0` and the block is not busy, the addressed word appears on `rp_rdata` with `rp_rvalid=1` after the next clock edge.
- R3: A row transfer copies the whole of the row as it stands when the transfer starts. Two edges after the start, `ser_data` shows the word at the requested offset `xfr_off`.
- R4: Each clock edge with `ser_en=1` moves `ser_data` to the next column. After column COLS-1 it goes to column 0. With `ser_en=0`, and no copy landing, `ser_data` holds its value.
- R5: A transfer that starts raises `rp_busy` on the edge after `xfr_req`, provided the block is idle and `rp_req=0`. `rp_busy` then stays high for exactly two cycles.
- R6: A transfer requested in the same cycle as a random access waits until that access is done. `rp_busy` rises one edge later than it otherwise would, and a write made by that access is included in the copied row.
- R7: Random requests made while `rp_busy=1` are dropped. They write nothing, and they produce no `rp_rvalid`.
- R8: Random writes made after a transfer has completed leave the serial stream unchanged. This holds for writes to any row, including the row that was copied, and for writes made in the same cycles as serial steps.
- R9: A transfer that lands while the serial register is part-way through a row overwrites the register and restarts the stream at the new offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| rst_n | input | 1 | Synchronous reset, active low |
| rp_req | input | 1 | Random access request |
| rp_we | input | 1 | 1 = write, 0 = read |
| rp_row | input | ROW_W | Random access row |
| rp_col | input | COL_W | Random access column (word index) |
| rp_wdata | input | WORD_BITS | Write data |
| rp_rdata | output | WORD_BITS | Read data, registered |
| rp_rvalid | output | 1 | Read data valid |
| rp_busy | output | 1 | Random port stalled by a row transfer |
| xfr_req | input | 1 | Row transfer request (single-cycle pulse) |
| xfr_row | input | ROW_W | Row to copy to the serial register |
| xfr_off | input | COL_W | Column at which serial output starts |
| ser_en | input | 1 | Serial step strobe |
| ser_data | output | WORD_BITS | Current serial word |

## Verification
The bench goes after the edges of the serial column pointer. A start offset next to the last column, followed by steps past it, shows whether a pointer that fails to wrap, or that wraps one column early, emits the wrong word. A transfer requested together with a random write checks that the copy waits for the write: a design that opens the row too soon would emit the word as it was before the write. Random writes issued during the stall, and writes issued during serial stepping (including writes to the copied row), expose a design that lets the stall leak, or that streams live array data instead of the snapshot. A second transfer arriving mid-stream checks that the pointer restarts at the new offset rather than carrying on from the old position.

// File: rtl/vfb_pkg.sv
// Shared types and helpers for the dual-port frame buffer.
// Assumes: nothing beyond standard SystemVerilog.
package vfb_pkg;

    // Transfer controller phases: idle, row open (latch filled), copy into serial register.
    typedef enum logic [1:0] {
        XF_IDLE = 2'd0,
        XF_OPEN = 2'd1,
        XF_COPY = 2'd2
    } xfer_state_t;

    // Index width for a count, never below one bit.
    function automatic int idx_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/vfb_array.sv
// Storage array with a word-wide random port and a row-wide latch.
// Assumes: the caller only raises wr_en/rd_en when no transfer is active,
// and open_en is never raised in the same cycle as wr_en.
module vfb_array #(
    parameter int ROWS      = 8,
    parameter int ROW_BITS  = 64,
    parameter int WORD_BITS = 8,
    localparam int COLS     = ROW_BITS / WORD_BITS,
    localparam int ROW_W    = vfb_pkg::idx_w(ROWS),
    localparam int COL_W    = vfb_pkg::idx_w(COLS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic                 rd_en,
    input  logic [ROW_W-1:0]     acc_row,
    input  logic [COL_W-1:0]     acc_col,
    input  logic [WORD_BITS-1:0] wdata,
    output logic [WORD_BITS-1:0] rdata,
    output logic                 rvalid,
    input  logic                 open_en,
    input  logic [ROW_W-1:0]     open_row,
    output logic [ROW_BITS-1:0]  row_latch
);

    logic [ROW_BITS-1:0] mem [ROWS];

    // Word write into the array; contents are not reset.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            for (int c = 0; c < COLS; c++) begin
                if (acc_col == COL_W'(c)) begin
                    mem[acc_row][c*WORD_BITS +: WORD_BITS] <= wdata;
                end
            end
        end
    end

    // Registered word read for the random port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata  <= '0;
            rvalid <= 1'b0;
        end else begin
            rvalid <= rd_en;
            if (rd_en) begin
                for (int c = 0; c < COLS; c++) begin
                    if (acc_col == COL_W'(c)) begin
                        rdata <= mem[acc_row][c*WORD_BITS +: WORD_BITS];
                    end
                end
            end
        end
    end

    // Open a whole row into the row latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_latch <= '0;
        end else if (open_en) begin
            row_latch <= mem[open_row];
        end
    end

endmodule

// File: rtl/vfb_xfer_ctrl.sv
// Row-transfer sequencer: holds a request until the random port is free,
// then opens the row (one cycle) and copies the latch (one cycle).
// Assumes: acc_req reflects a random access presented in the current cycle.
module vfb_xfer_ctrl #(
    parameter int ROW_W = 3,
    parameter int COL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             xfr_req,
    input  logic [ROW_W-1:0] xfr_row,
    input  logic [COL_W-1:0] xfr_off,
    input  logic             acc_req,
    output logic             busy,
    output logic             open_en,
    output logic [ROW_W-1:0] open_row,
    output logic             load_en,
    output logic [COL_W-1:0] load_off
);
    import vfb_pkg::*;

    xfer_state_t      state;
    logic             pend;
    logic [ROW_W-1:0] pend_row;
    logic [COL_W-1:0] pend_off;
    logic [COL_W-1:0] cur_off;
    logic             start;
    logic [COL_W-1:0] go_off;

    // Start when idle, a request is present or pending, and no access is in flight.
    always_comb begin
        start    = (state == XF_IDLE) && (xfr_req || pend) && !acc_req;
        open_row = xfr_req ? xfr_row : pend_row;
        go_off   = xfr_req ? xfr_off : pend_off;
    end

    // Phase sequencing and capture of deferred requests.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= XF_IDLE;
            pend     <= 1'b0;
            pend_row <= '0;
            pend_off <= '0;
            cur_off  <= '0;
        end else begin
            if (start) begin
                pend    <= 1'b0;
                cur_off <= go_off;
            end else if (xfr_req) begin
                pend     <= 1'b1;
                pend_row <= xfr_row;
                pend_off <= xfr_off;
            end
            case (state)
                XF_IDLE: if (start) state <= XF_OPEN;
                XF_OPEN: state <= XF_COPY;
                default: state <= XF_IDLE;
            endcase
        end
    end

    // Phase decode toward the array and the serial register.
    always_comb begin
        busy     = (state != XF_IDLE);
        open_en  = start;
        load_en  = (state == XF_OPEN);
        load_off = cur_off;
    end

endmodule

// File: rtl/vfb_serial.sv
// Serial register: loaded a full row at a time, stepped one word per strobe,
// wrapping from the last column to column zero.
// Assumes: ROW_BITS is a multiple of WORD_BITS.
module vfb_serial #(
    parameter int ROW_BITS  = 64,
    parameter int WORD_BITS = 8,
    localparam int COLS     = ROW_BITS / WORD_BITS,
    localparam int COL_W    = vfb_pkg::idx_w(COLS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load_en,
    input  logic [ROW_BITS-1:0]  load_row,
    input  logic [COL_W-1:0]     load_off,
    input  logic                 shift_en,
    output logic [WORD_BITS-1:0] ser_data
);

    logic [ROW_BITS-1:0]  sreg;
    logic [COL_W-1:0]     ptr;
    logic [WORD_BITS-1:0] words [COLS];

    // Split the register into its words.
    for (genvar g = 0; g < COLS; g++) begin : g_word
        assign words[g] = sreg[g*WORD_BITS +: WORD_BITS];
    end

    // Row load overrides stepping; stepping wraps after the last column.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sreg <= '0;
            ptr  <= '0;
        end else if (load_en) begin
            sreg <= load_row;
            ptr  <= load_off;
        end else if (shift_en) begin
            ptr <= (ptr == COL_W'(COLS - 1)) ? '0 : ptr + 1'b1;
        end
    end

    // Present the current word.
    always_comb begin
        ser_data = words[ptr];
    end

endmodule

// File: rtl/vfb_top.sv
// Dual-port frame buffer: a random word port on the array plus a serial
// port fed by whole-row transfers. Random accesses are dropped while busy.
// Assumes: single shared clock, xfr_req is a one-cycle pulse.
module vfb_top #(
    parameter int ROWS      = 8,
    parameter int ROW_BITS  = 64,
    parameter int WORD_BITS = 8,
    localparam int COLS     = ROW_BITS / WORD_BITS,
    localparam int ROW_W    = vfb_pkg::idx_w(ROWS),
    localparam int COL_W    = vfb_pkg::idx_w(COLS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rp_req,
    input  logic                 rp_we,
    input  logic [ROW_W-1:0]     rp_row,
    input  logic [COL_W-1:0]     rp_col,
    input  logic [WORD_BITS-1:0] rp_wdata,
    output logic [WORD_BITS-1:0] rp_rdata,
    output logic                 rp_rvalid,
    output logic                 rp_busy,
    input  logic                 xfr_req,
    input  logic [ROW_W-1:0]     xfr_row,
    input  logic [COL_W-1:0]     xfr_off,
    input  logic                 ser_en,
    output logic [WORD_BITS-1:0] ser_data
);

    if (ROW_BITS % WORD_BITS != 0) begin : g_bad_width
        $error("ROW_BITS must be a multiple of WORD_BITS");
    end

    logic                wr_en;
    logic                rd_en;
    logic                open_en;
    logic [ROW_W-1:0]    open_row;
    logic                load_en;
    logic [COL_W-1:0]    load_off;
    logic [ROW_BITS-1:0] row_latch;

    // Gate random requests with the transfer stall.
    always_comb begin
        wr_en = rp_req &&  rp_we && !rp_busy;
        rd_en = rp_req && !rp_we && !rp_busy;
    end

    vfb_xfer_ctrl #(.ROW_W(ROW_W), .COL_W(COL_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .xfr_req  (xfr_req),
        .xfr_row  (xfr_row),
        .xfr_off  (xfr_off),
        .acc_req  (rp_req),
        .busy     (rp_busy),
        .open_en  (open_en),
        .open_row (open_row),
        .load_en  (load_en),
        .load_off (load_off)
    );

    vfb_array #(.ROWS(ROWS), .ROW_BITS(ROW_BITS), .WORD_BITS(WORD_BITS)) u_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .rd_en     (rd_en),
        .acc_row   (rp_row),
        .acc_col   (rp_col),
        .wdata     (rp_wdata),
        .rdata     (rp_rdata),
        .rvalid    (rp_rvalid),
        .open_en   (open_en),
        .open_row  (open_row),
        .row_latch (row_latch)
    );

    vfb_serial #(.ROW_BITS(ROW_BITS), .WORD_BITS(WORD_BITS)) u_serial (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_en  (load_en),
        .load_row (row_latch),
        .load_off (load_off),
        .shift_en (ser_en),
        .ser_data (ser_data)
    );

endmodule

// File: rtl/vfb_checker.sv
// Protocol checker for vfb_top, attached by bind.
module vfb_checker #(
    parameter int WORD_BITS = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 rp_req,
    input logic                 rp_we,
    input logic                 rp_busy,
    input logic                 rp_rvalid,
    input logic                 ser_en,
    input logic [WORD_BITS-1:0] ser_data
);

    AST_STALL_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rp_busy) |=> rp_busy);                                  // R5
    AST_STALL_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rp_busy) |=> ##1 !rp_busy);                             // R5
    AST_HOLD_FOR_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        (rp_req && !rp_busy) |=> !rp_busy);                           // R6
    AST_READ_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (rp_req && !rp_we && !rp_busy) |=> rp_rvalid);                // R2
    AST_BUSY_DROPS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (rp_req && rp_busy) |=> !rp_rvalid);                          // R7
    AST_SER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!ser_en && !rp_busy) |=> $stable(ser_data));                 // R4

endmodule

bind vfb_top vfb_checker #(.WORD_BITS(WORD_BITS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rp_req    (rp_req),
    .rp_we     (rp_we),
    .rp_busy   (rp_busy),
    .rp_rvalid (rp_rvalid),
    .ser_en    (ser_en),
    .ser_data  (ser_data)
);

// File: tb/tb_vfb_top.sv
module tb_vfb_top;
    localparam int CLK_PERIOD = 10;
    localparam int ROWS = 8;
    localparam int ROW_BITS = 64;
    localparam int WB = 8;
    localparam int COLS = ROW_BITS / WB;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rp_req = 0, rp_we = 0, xfr_req = 0, ser_en = 0;
    logic [2:0] rp_row = 0, rp_col = 0, xfr_row = 0, xfr_off = 0;
    logic [7:0] rp_wdata = 0;
    logic [7:0] rp_rdata, ser_data;
    logic rp_rvalid, rp_busy;

    int n_chk = 0;
    int n_bad = 0;
    logic done = 1'b0;
    logic [7:0] model [ROWS][COLS];
    logic [7:0] snap [COLS];
    int spos = 0;

    // {row[2:0], col[2:0], data[7:0]}
    localparam logic [13:0] VEC [8] = '{
        {3'd0, 3'd0, 8'h11}, {3'd0, 3'd7, 8'hE7}, {3'd7, 3'd0, 8'h70},
        {3'd7, 3'd7, 8'hFF}, {3'd3, 3'd4, 8'h00}, {3'd5, 3'd2, 8'hA5},
        {3'd2, 3'd6, 8'h5A}, {3'd6, 3'd3, 8'hC3}
    };

    always #(CLK_PERIOD / 2) clk = ~clk;

    vfb_top #(.ROWS(ROWS), .ROW_BITS(ROW_BITS), .WORD_BITS(WB)) dut (
        .clk(clk), .rst_n(rst_n), .rp_req(rp_req), .rp_we(rp_we),
        .rp_row(rp_row), .rp_col(rp_col), .rp_wdata(rp_wdata),
        .rp_rdata(rp_rdata), .rp_rvalid(rp_rvalid), .rp_busy(rp_busy),
        .xfr_req(xfr_req), .xfr_row(xfr_row), .xfr_off(xfr_off),
        .ser_en(ser_en), .ser_data(ser_data)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] pat(input int r, input int c);
        return 8'(r * 37 + c * 11 + 5);
    endfunction

    task automatic wr(input int r, input int c, input logic [7:0] d);
        rp_req = 1; rp_we = 1; rp_row = 3'(r); rp_col = 3'(c); rp_wdata = d;
        tick();
        rp_req = 0; rp_we = 0;
        model[r][c] = d;
    endtask

    task automatic rd(input string req, input int r, input int c);
        rp_req = 1; rp_we = 0; rp_row = 3'(r); rp_col = 3'(c);
        tick();
        rp_req = 0;
        check(req, {15'd0, rp_rvalid}, 16'd1);
        check(req, {8'd0, rp_rdata}, {8'd0, model[r][c]});
    endtask

    // Idle transfer: busy on edges 1 and 2, first word after edge 2, idle after edge 3.
    task automatic xfer(input int r, input int off);
        xfr_req = 1; xfr_row = 3'(r); xfr_off = 3'(off);
        for (int c = 0; c < COLS; c++) snap[c] = model[r][c];
        spos = off;
        tick();
        xfr_req = 0;
        check("R5 busy cycle1", {15'd0, rp_busy}, 16'd1);
        tick();
        check("R5 busy cycle2", {15'd0, rp_busy}, 16'd1);
        check("R3 first word at offset", {8'd0, ser_data}, {8'd0, snap[off]});
        tick();
        check("R5 busy released", {15'd0, rp_busy}, 16'd0);
        check("R3 word held after copy", {8'd0, ser_data}, {8'd0, snap[off]});
    endtask

    task automatic shift_n(input string req, input int n);
        for (int k = 0; k < n; k++) begin
            ser_en = 1;
            tick();
            spos = (spos + 1) % COLS;
            check(req, {8'd0, ser_data}, {8'd0, snap[spos]});
        end
        ser_en = 0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) tick();
        check("R1 busy in reset", {15'd0, rp_busy}, 16'd0);
        check("R1 rvalid in reset", {15'd0, rp_rvalid}, 16'd0);
        check("R1 ser_data in reset", {8'd0, ser_data}, 16'd0);
        rst_n = 1;
        tick();
        check("R1 ser_data after reset", {8'd0, ser_data}, 16'd0);

        // R2: fill every word, then table of overrides written and read back
        for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < COLS; c++) wr(r, c, pat(r, c));
        for (int i = 0; i < 8; i++) wr(int'(VEC[i][13:11]), int'(VEC[i][10:8]), VEC[i][7:0]);
        for (int i = 0; i < 8; i++) rd("R2 table readback", int'(VEC[i][13:11]), int'(VEC[i][10:8]));
        rd("R2 untouched word", 4, 1);

        // R3/R4: transfer row 2 from column 0, step past the end
        xfer(2, 0);
        shift_n("R4 step and wrap", COLS + 1);
        tick();
        check("R4 hold without strobe", {8'd0, ser_data}, {8'd0, snap[spos]});

        // R4: offset next to last column, wrap early
        xfer(7, 6);
        shift_n("R4 wrap from offset 6", 4);

        // R8: writes during stepping, including the copied row
        xfer(3, 1);
        for (int k = 0; k < COLS; k++) begin
            ser_en = 1;
            rp_req = 1; rp_we = 1;
            rp_row = (k % 2 == 0) ? 3'd3 : 3'd5;
            rp_col = 3'((spos + 1) % COLS);
            rp_wdata = 8'(8'h80 + k);
            tick();
            model[int'(rp_row)][int'(rp_col)] = rp_wdata;
            spos = (spos + 1) % COLS;
            check("R8 stream keeps snapshot", {8'd0, ser_data}, {8'd0, snap[spos]});
        end
        ser_en = 0; rp_req = 0; rp_we = 0;
        rd("R8 write landed in array", 3, int'((1 + 7) % COLS));

        // R9: retransfer mid-stream resets pointer
        xfer(0, 0);
        shift_n("R9 before retransfer", 3);
        xfer(6, 2);
        shift_n("R9 restarted stream", COLS);

        // R6: transfer requested with a write to the same word
        rp_req = 1; rp_we = 1; rp_row = 3'd4; rp_col = 3'd4; rp_wdata = 8'hAA;
        xfr_req = 1; xfr_row = 3'd4; xfr_off = 3'd4;
        tick();
        model[4][4] = 8'hAA;
        rp_req = 0; rp_we = 0; xfr_req = 0;
        check("R6 deferred, not busy", {15'd0, rp_busy}, 16'd0);
        tick();
        check("R6 busy one edge late", {15'd0, rp_busy}, 16'd1);
        tick();
        check("R6 busy second cycle", {15'd0, rp_busy}, 16'd1);
        check("R6 copy includes write", {8'd0, ser_data}, 16'h00AA);
        tick();
        check("R6 busy released", {15'd0, rp_busy}, 16'd0);

        // R7: requests during the stall are dropped
        xfr_req = 1; xfr_row = 3'd1; xfr_off = 3'd0;
        tick();
        xfr_req = 0;
        rp_req = 1; rp_we = 1; rp_row = 3'd6; rp_col = 3'd0; rp_wdata = 8'h3C;
        tick();
        check("R7 no rvalid on dropped write", {15'd0, rp_rvalid}, 16'd0);
        rp_we = 0;
        tick();
        rp_req = 0;
        check("R7 no rvalid on dropped read", {15'd0, rp_rvalid}, 16'd0);
        rd("R7 dropped write left word", 6, 0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule